// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Reload Buffer

This block is a free-running up-counter driven by a tick qualifier. A prescaler divides the tick by a programmable ratio. Each prescaled tick advances a counter that wraps to zero once it reaches an active reload value. That wrap, or a software request, forms an *update event*. An update event clears the prescaler and the counter, can copy a buffered reload value into the active compare register, can set an interrupt flag, and can halt the counter when one-shot operation is selected. Software reaches all of this through a small register bus: eight word addresses, a write strobe and a combinational read path.

A filter bit limits flag setting to genuine overflows, so that software can realign the counter without raising an interrupt. A separate bit blocks update events altogether. A registered trigger output carries one of three internal sources to neighbouring logic: the software request pulse, the run state, or the update event.

Top module: `tick_timer32`

## Requirements
- R1: After reset every register (addresses 0 to 7) reads 0, and `irq` and `trig_out` are 0.
- R2: With run set (control bit 0) and `tick_en` high, an overflow update occurs every (P+1)*(A+1) clock cycles, where P is the prescaler (address 6) and A the active reload value. The counter counts 0..A. While `tick_en` is low the counter and prescaler hold.
- R3: The counter (address 5), prescaler (address 6) and reload (address 7) are each CNT_W bits wide and read back what was written, with bits above CNT_W reading 0. With reload 2^CNT_W-1 the counter reaches its maximum and then overflows.
- R4: When one-shot is set (control bit 3), an overflow update clears run (control bit 0). A software update leaves run set.
- R5: With the overflow-only bit (control bit 2) at 0, both overflow and software updates set the flag. With it at 1, only overflow sets the flag.
- R6: With update-off (control bit 1) set, no update event occurs: software requests neither clear the counter nor set the flag, and overflow still wraps the counter to 0 but sets no flag.
- R7: The flag is status bit 0 (address 3). Writing 1 there clears it and writing 0 leaves it unchanged. A set in the same cycle wins over a clear. `irq` equals the flag ANDed with interrupt-enable bit 0 (address 2).
- R8: Writing 1 to bit 0 of address 4 requests a software update, which zeroes the counter and the prescaler. Address 4 always reads 0.
- R9: With reload buffering (control bit 7) at 1, a reload write lands in a buffer and becomes active at the next update event. With it at 0 the write is active at once. Address 7 reads the last written value.
- R10: Trigger select is bits [6:4] of address 1. Value 0 routes the software request pulse, 1 the run state, 2 the update event, and any other value gives 0. `trig_out` is registered and shows the selected source from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Tick qualifier feeding the prescaler |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Update interrupt request |
| trig_out | output | 1 | Registered trigger output |

## Verification
The bench builds the timer with CNT_W = 8 and keeps the bus at 32 bits. This makes the full-range wrap at 255 and the truncation of the upper write bits observable in a few cycles. Under that configuration every prescaler value 0..3 is swept against every reload value 0..4. For each pair the bench checks the cycle of the first flag and the count of update pulses on the trigger output against (P+1)*(A+1). The small widths also keep the reload-buffer hand-over, one-shot stop and filter corner cases short enough to check cycle by cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_TRIG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVGEN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd6;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd7;

  localparam int B_RUN      = 0;
  localparam int B_UPD_OFF  = 1;
  localparam int B_OVF_ONLY = 2;
  localparam int B_ONE_SHOT = 3;
  localparam int B_RLD_BUF  = 7;

  localparam int TSEL_LSB = 4;
  localparam int TSEL_W   = 3;

  typedef enum logic [TSEL_W-1:0] {
    TRG_SWREQ  = 3'd0,
    TRG_RUN    = 3'd1,
    TRG_UPDATE = 3'd2
  } trg_src_e;

  typedef struct packed {
    logic rld_buf;
    logic one_shot;
    logic ovf_only;
    logic upd_off;
    logic run;
  } ctl_t;
endpackage

// File: rtl/tt_regfile.sv
module tt_regfile
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              hw_stop,
  input  logic              flag_set,
  output ctl_t              ctl,
  output logic [TSEL_W-1:0] tsel,
  output logic              ien,
  output logic              flag,
  output logic              sw_req,
  output logic              cnt_load,
  output logic              rld_load,
  output logic [CNT_W-1:0]  psc_val,
  output logic [CNT_W-1:0]  rld_shadow
);
  ctl_t              ctl_q, ctl_d;
  logic [TSEL_W-1:0] tsel_q, tsel_d;
  logic              ien_q, ien_d;
  logic              flag_q, flag_d;
  logic [CNT_W-1:0]  psc_q, psc_d;
  logic [CNT_W-1:0]  rld_q, rld_d;

  logic wr_ctrl, wr_trig, wr_ien, wr_stat, wr_evgen, wr_psc, wr_rld, wr_cnt;

  always_comb begin
    wr_ctrl  = bus_we && (bus_addr == A_CTRL);
    wr_trig  = bus_we && (bus_addr == A_TRIG);
    wr_ien   = bus_we && (bus_addr == A_IEN);
    wr_stat  = bus_we && (bus_addr == A_STAT);
    wr_evgen = bus_we && (bus_addr == A_EVGEN);
    wr_cnt   = bus_we && (bus_addr == A_COUNT);
    wr_psc   = bus_we && (bus_addr == A_PSC);
    wr_rld   = bus_we && (bus_addr == A_RELOAD);
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctrl) begin
      ctl_d.run      = bus_wdata[B_RUN];
      ctl_d.upd_off  = bus_wdata[B_UPD_OFF];
      ctl_d.ovf_only = bus_wdata[B_OVF_ONLY];
      ctl_d.one_shot = bus_wdata[B_ONE_SHOT];
      ctl_d.rld_buf  = bus_wdata[B_RLD_BUF];
    end
    // hardware stop of a one-shot run beats a same-cycle software write
    if (hw_stop) ctl_d.run = 1'b0;

    tsel_d = wr_trig ? bus_wdata[TSEL_LSB +: TSEL_W] : tsel_q;
    ien_d  = wr_ien ? bus_wdata[0] : ien_q;
    psc_d  = wr_psc ? bus_wdata[CNT_W-1:0] : psc_q;
    rld_d  = wr_rld ? bus_wdata[CNT_W-1:0] : rld_q;

    flag_d = flag_q;
    if (wr_stat && bus_wdata[0]) flag_d = 1'b0;
    if (flag_set)                flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      tsel_q <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      psc_q  <= '0;
      rld_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      tsel_q <= tsel_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
      psc_q  <= psc_d;
      rld_q  <= rld_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_RUN]      = ctl_q.run;
        bus_rdata[B_UPD_OFF]  = ctl_q.upd_off;
        bus_rdata[B_OVF_ONLY] = ctl_q.ovf_only;
        bus_rdata[B_ONE_SHOT] = ctl_q.one_shot;
        bus_rdata[B_RLD_BUF]  = ctl_q.rld_buf;
      end
      A_TRIG:   bus_rdata[TSEL_LSB +: TSEL_W] = tsel_q;
      A_IEN:    bus_rdata[0] = ien_q;
      A_STAT:   bus_rdata[0] = flag_q;
      A_COUNT:  bus_rdata = DATA_W'(cnt_val);
      A_PSC:    bus_rdata = DATA_W'(psc_q);
      A_RELOAD: bus_rdata = DATA_W'(rld_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign ctl        = ctl_q;
  assign tsel       = tsel_q;
  assign ien        = ien_q;
  assign flag       = flag_q;
  assign sw_req     = wr_evgen && bus_wdata[0];
  assign cnt_load   = wr_cnt;
  assign rld_load   = wr_rld;
  assign psc_val    = psc_q;
  assign rld_shadow = rld_q;

  // R8: the event register never returns a set bit
  p_evgen_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_EVGEN) |-> (bus_rdata == '0));
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             upd_off,
  input  logic             ovf_only,
  input  logic             rld_buf,
  input  logic             sw_req,
  input  logic             cnt_load,
  input  logic             rld_load,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] psc_val,
  input  logic [CNT_W-1:0] rld_shadow,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_upd,
  output logic             upd,
  output logic             flag_set
);
  logic [CNT_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic step, psc_hit, cnt_tick, ovf, sw_upd;

  always_comb begin
    step     = run && tick_en;
    psc_hit  = (psc_q >= psc_val);
    cnt_tick = step && psc_hit;
    ovf      = cnt_tick && (cnt_q >= act_q);
    ovf_upd  = ovf && !upd_off;
    sw_upd   = sw_req && !upd_off;
    upd      = ovf_upd || sw_upd;
    flag_set = ovf_upd || (sw_upd && !ovf_only);
  end

  always_comb begin
    if (upd)       psc_d = '0;
    else if (step) psc_d = psc_hit ? '0 : psc_q + 1'b1;
    else           psc_d = psc_q;

    if (upd)           cnt_d = '0;
    else if (cnt_load) cnt_d = wdata;
    else if (ovf)      cnt_d = '0;
    else if (cnt_tick) cnt_d = cnt_q + 1'b1;
    else               cnt_d = cnt_q;

    if (rld_load && !rld_buf) act_d = wdata;
    else if (upd && rld_buf)  act_d = rld_shadow;
    else                      act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      psc_q <= psc_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cnt_val = cnt_q;

  // R8: any update event leaves the counter at zero on the next cycle
  p_upd_zeroes_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt_val == '0));
endmodule

// File: rtl/tt_trig_out.sv
module tt_trig_out
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              sw_req,
  input  logic              run,
  input  logic              upd,
  output logic              trig_out
);
  logic trig_d, trig_q;

  always_comb begin
    case (tsel)
      TRG_SWREQ:  trig_d = sw_req;
      TRG_RUN:    trig_d = run;
      TRG_UPDATE: trig_d = upd;
      default:    trig_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig_out = trig_q;
endmodule

// File: rtl/tick_timer32.sv
module tick_timer32
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              trig_out
);
  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  ctl_t              ctl;
  logic [TSEL_W-1:0] tsel;
  logic              ien, flag, sw_req, cnt_load, rld_load;
  logic [CNT_W-1:0]  psc_val, rld_shadow, cnt_val;
  logic              ovf_upd, upd, flag_set, hw_stop;

  assign hw_stop = ovf_upd && ctl.one_shot;

  tt_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cnt_val    (cnt_val),
    .hw_stop    (hw_stop),
    .flag_set   (flag_set),
    .ctl        (ctl),
    .tsel       (tsel),
    .ien        (ien),
    .flag       (flag),
    .sw_req     (sw_req),
    .cnt_load   (cnt_load),
    .rld_load   (rld_load),
    .psc_val    (psc_val),
    .rld_shadow (rld_shadow)
  );

  tt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tick_en    (tick_en),
    .run        (ctl.run),
    .upd_off    (ctl.upd_off),
    .ovf_only   (ctl.ovf_only),
    .rld_buf    (ctl.rld_buf),
    .sw_req     (sw_req),
    .cnt_load   (cnt_load),
    .rld_load   (rld_load),
    .wdata      (bus_wdata[CNT_W-1:0]),
    .psc_val    (psc_val),
    .rld_shadow (rld_shadow),
    .cnt_val    (cnt_val),
    .ovf_upd    (ovf_upd),
    .upd        (upd),
    .flag_set   (flag_set)
  );

  tt_trig_out u_trig (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .tsel     (tsel),
    .sw_req   (sw_req),
    .run      (ctl.run),
    .upd      (upd),
    .trig_out (trig_out)
  );

  assign irq = flag && ien;

  // R4: a one-shot overflow update drops the run bit
  p_one_shot_stop_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ovf_upd && ctl.one_shot) |=> !ctl.run);

  // R6: with update events off the flag cannot rise
  p_upd_off_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl.upd_off && !flag) |=> !flag);

  // R5: a software request alone does not raise the flag in overflow-only mode
  p_ovf_only_filter_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl.ovf_only && sw_req && !ovf_upd && !flag) |=> !flag);
endmodule

// File: tb/tick_timer32_tb_top.sv
`timescale 1ns/1ps
module tick_timer32_tb_top;
  import tick_timer_pkg::*;

  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk;
  logic          rst_n;
  logic          tick_en;
  logic [2:0]    bus_addr;
  logic          bus_we;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          irq;
  logic          trig_out;

  int n_chk  = 0;
  int n_fail = 0;

  tick_timer32 #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .trig_out  (trig_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  logic [31:0] v;
  int first, pulses, second, n;

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 trig", {31'd0, trig_out}, 0);

    // R2: sweep prescaler 0..3 x reload 0..4; trigger on update (sel 2)
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 5; a++) begin
        wr(A_CTRL, 32'h4);
        wr(A_PSC, p);
        wr(A_RELOAD, a);
        wr(A_TRIG, 32'h20);
        wr(A_EVGEN, 32'h1);
        wr(A_STAT, 32'h1);
        wr(A_CTRL, 32'h5);
        first = 0; pulses = 0;
        for (int j = 1; j <= 60; j++) begin
          @(negedge clk);
          rd(A_STAT, v);
          if (v[0] && first == 0) first = j;
          if (trig_out) pulses++;
        end
        chk($sformatf("R2 first flag p=%0d a=%0d", p, a), first, (p+1)*(a+1));
        chk($sformatf("R10 update pulses p=%0d a=%0d", p, a), pulses, 60/((p+1)*(a+1)));
        wr(A_CTRL, 32'h4);
      end
    end

    // R2: tick_en low freezes the count
    wr(A_RELOAD, 100); wr(A_CNT_FIX(), 0);
    tick_en = 1'b0;
    wr(A_CTRL, 32'h5);
    repeat (5) @(negedge clk);
    rd(A_COUNT, v); chk("R2 tick_en low holds", v, 0);
    wr(A_CTRL, 32'h4);
    tick_en = 1'b1;

    // R3: widths and full-range wrap
    wr(A_COUNT, 32'h1FF);    rd(A_COUNT, v);  chk("R3 count width", v, 32'hFF);
    wr(A_PSC, 32'hABCD);     rd(A_PSC, v);    chk("R3 prescaler width", v, 32'hCD);
    wr(A_RELOAD, 32'h1234);  rd(A_RELOAD, v); chk("R3 reload width", v, 32'h34);
    wr(A_PSC, 0); wr(A_RELOAD, 255); wr(A_COUNT, 250); wr(A_STAT, 1);
    wr(A_CTRL, 32'h5);
    n = 0;
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      rd(A_STAT, v);
      if (v[0] && n == 0) n = j;
    end
    chk("R3 wrap at 255", n, 6);
    wr(A_CTRL, 32'h4);

    // R8, R5, R7: software update, filter, flag clear and irq
    wr(A_CTRL, 32'h0); wr(A_STAT, 1);
    wr(A_COUNT, 7); rd(A_COUNT, v); chk("R8 preload count", v, 7);
    wr(A_EVGEN, 1);
    rd(A_COUNT, v); chk("R8 sw update zeroes count", v, 0);
    rd(A_STAT, v);  chk("R5 sw update sets flag", v, 1);
    rd(A_EVGEN, v); chk("R8 event reads 0", v, 0);
    wr(A_STAT, 0);  rd(A_STAT, v); chk("R7 write 0 keeps flag", v, 1);
    chk("R7 irq off while disabled", {31'd0, irq}, 0);
    wr(A_IEN, 1);   chk("R7 irq on", {31'd0, irq}, 1);
    wr(A_STAT, 1);  rd(A_STAT, v); chk("R7 write 1 clears", v, 0);
    chk("R7 irq drops", {31'd0, irq}, 0);
    wr(A_CTRL, 32'h4); wr(A_EVGEN, 1);
    rd(A_STAT, v); chk("R5 filtered sw update", v, 0);

    // R6: update-off blocks events
    wr(A_COUNT, 9); wr(A_CTRL, 32'h2); wr(A_EVGEN, 1);
    rd(A_COUNT, v); chk("R6 count kept", v, 9);
    rd(A_STAT, v);  chk("R6 no flag on sw", v, 0);
    wr(A_PSC, 0); wr(A_RELOAD, 2); wr(A_COUNT, 0); wr(A_CTRL, 32'h3);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h2);
    rd(A_STAT, v);  chk("R6 no flag on overflow", v, 0);
    rd(A_COUNT, v); chk("R6 counter still wraps", {31'd0, (v <= 2)}, 1);

    // R4: one-shot
    wr(A_CTRL, 32'h4); wr(A_STAT, 1); wr(A_PSC, 0); wr(A_RELOAD, 3); wr(A_COUNT, 0);
    wr(A_CTRL, 32'hD);
    repeat (10) @(negedge clk);
    rd(A_CTRL, v);  chk("R4 run cleared", v, 32'hC);
    rd(A_COUNT, v); chk("R4 count parked", v, 0);
    rd(A_STAT, v);  chk("R4 flag set", v, 1);
    wr(A_RELOAD, 200); wr(A_COUNT, 0); wr(A_CTRL, 32'hD); wr(A_EVGEN, 1);
    rd(A_CTRL, v);  chk("R4 sw update keeps run", v, 32'hD);
    wr(A_CTRL, 32'h4);

    // R9: reload buffering
    wr(A_RELOAD, 4);
    wr(A_CTRL, 32'h84);
    wr(A_RELOAD, 1);
    rd(A_RELOAD, v); chk("R9 reload reads written", v, 1);
    wr(A_COUNT, 0); wr(A_TRIG, 32'h20);
    wr(A_CTRL, 32'h85);
    first = 0; second = 0;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (trig_out) begin
        if (first == 0) first = j;
        else if (second == 0) second = j;
      end
    end
    chk("R9 old reload until update", first, 5);
    chk("R9 buffered reload after update", second, 7);
    wr(A_CTRL, 32'h4);

    // R10: trigger sources
    wr(A_TRIG, 32'h10);
    wr(A_CTRL, 32'h5);
    chk("R10 run lag", {31'd0, trig_out}, 0);
    @(negedge clk);
    chk("R10 run follows", {31'd0, trig_out}, 1);
    wr(A_CTRL, 32'h4);
    @(negedge clk);
    chk("R10 run off", {31'd0, trig_out}, 0);
    wr(A_TRIG, 32'h00);
    wr(A_EVGEN, 1);
    chk("R10 sw pulse high", {31'd0, trig_out}, 1);
    @(negedge clk);
    chk("R10 sw pulse ends", {31'd0, trig_out}, 0);
    wr(A_TRIG, 32'h30);
    wr(A_EVGEN, 1);
    chk("R10 unused select", {31'd0, trig_out}, 0);
    @(negedge clk);
    chk("R10 unused select later", {31'd0, trig_out}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  function automatic logic [2:0] A_CNT_FIX();
    return A_COUNT;
  endfunction
endmodule